// File: doc/BRIEF.md
# External Interrupt Normalization Unit

This unit takes 32 asynchronous interrupt lines from outside the chip and turns each into a clean, active-high level request for a downstream interrupt controller. It does not merge the lines: line n always drives output n. Each line has its own sense mode, which is level or edge, and its own polarity. Every input is first synchronized to the local clock. Edge events set a sticky request that holds until software clears it. Level requests simply follow the line.

Software reaches the unit through a 32-bit register port with one bit per line in every register. The port has a per-line mask, polarity and sense-mode bits, and a raw status and a masked status. It also has a write-one-to-clear register for latched requests and a software request register that raises a request as if an edge had occurred. A request is latched even while its line is masked. Software can see it in the raw status and clear it before it unmasks the line.

Top module: `extirq_norm`

## Requirements
- R1: After reset, every mask bit is 1, every polarity bit is 1, every sense bit is 0, the source-select register is 0, no request is latched and all 32 outputs are 0.
- R2: Word registers sit at byte offsets 0x00 mask, 0x04 source select, 0x08 masked status, 0x0C raw status, 0x10 clear, 0x14 polarity, 0x18 sense mode and 0x1C software request. Mask, source select, polarity and sense mode read back what was written. Clear and software request read as zero. Writes to the two status offsets change nothing. Accesses whose low two address bits are not zero are ignored.
- R3: A mask bit of 1 holds that line's output at 0. A mask bit of 0 lets the line's request through.
- R4: With sense bit 0, the line is level sensitive and its raw status equals (input XNOR polarity bit) taken two clocks after the input is sampled. Polarity 1 means active high and polarity 0 means active low.
- R5: With sense bit 1, the line is edge sensitive. A rising edge (polarity 1) or a falling edge (polarity 0) sets a latched request three clocks after the new input level is sampled. The request stays set after the input returns.
- R6: An edge that arrives while its line is masked is still latched and shows in raw status. The masked status and the output stay 0 for that line.
- R7: Writing 1 to a bit of the clear register removes that line's latched request, and writing 0 leaves it set. A level-mode line whose input is still active stays requesting after a clear.
- R8: Writing 1 to a bit of the software request register latches a request on that line in either sense mode. Writing 0 has no effect.
- R9: The masked status and the output vector both equal raw status AND NOT mask on every cycle.
- R10: When a clear write and a newly detected edge on the same line take effect on the same clock, the request stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_line_i | input | 32 | Asynchronous external interrupt lines |
| bus_wr_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | 5 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 32 | Active-high level requests, one per line |

## Verification
The assertions check on every cycle that a masked line never drives its output, and that a latched request is removed only by a clear write. They also check that a software request always lands in the latch, and that an unmasked level-mode line whose input is active drives its output. The exact latencies need the bench's scenarios, run against a cycle model: two clocks for level mode and three for edge mode. So do the choice of rising or falling edge by polarity, the latching of an edge while the line is masked, and the outcome when a clear and an edge take effect together.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    localparam int unsigned REG_IDX_W = 3;

    typedef enum logic [REG_IDX_W-1:0] {
        RIX_MASK   = 3'd0,
        RIX_SRCSEL = 3'd1,
        RIX_MSTAT  = 3'd2,
        RIX_RSTAT  = 3'd3,
        RIX_CLEAR  = 3'd4,
        RIX_POL    = 3'd5,
        RIX_SENSE  = 3'd6,
        RIX_SWREQ  = 3'd7
    } reg_idx_e;

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] stage_d;
    logic [STAGES-1:0][W-1:0] stage_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb stage_d[g] = din;
        end else begin : g_next
            always_comb stage_d[g] = stage_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/extirq_detect.sv
module extirq_detect #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] sense_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] swset_i,
    output logic [W-1:0] lvl_act_o,
    output logic [W-1:0] sticky_o,
    output logic [W-1:0] raw_o
);

    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] sticky;
    } det_t;

    det_t st_d, st_q;
    logic [W-1:0] trig;

    // per-line edge qualification chosen by polarity
    for (genvar i = 0; i < W; i++) begin : g_line
        always_comb begin
            if (pol_i[i]) trig[i] = sync_i[i] & ~st_q.prev[i];
            else          trig[i] = ~sync_i[i] & st_q.prev[i];
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.prev   = sync_i;
        // new events win over a clear in the same cycle
        st_d.sticky = (st_q.sticky & ~clr_i) | (sense_i & trig) | swset_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_act_o = ~(sync_i ^ pol_i);
    assign sticky_o  = st_q.sticky;
    assign raw_o     = st_q.sticky | (~sense_i & lvl_act_o);

endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
    import extirq_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [W-1:0]  raw_i,
    input  logic [W-1:0]  masked_i,
    output logic [W-1:0]  rdata_o,
    output logic [W-1:0]  mask_o,
    output logic [W-1:0]  pol_o,
    output logic [W-1:0]  sense_o,
    output logic [W-1:0]  clr_o,
    output logic [W-1:0]  swset_o
);

    typedef struct packed {
        logic [W-1:0] mask;
        logic [W-1:0] src;
        logic [W-1:0] pol;
        logic [W-1:0] sense;
    } regs_t;

    regs_t    r_d, r_q;
    reg_idx_e idx;
    logic     aligned;
    logic     wr_ok;

    assign idx     = reg_idx_e'(addr_i[AW-1:2]);
    assign aligned = (addr_i[1:0] == 2'b00);
    assign wr_ok   = wr_i & aligned;

    always_comb begin
        r_d     = r_q;
        clr_o   = '0;
        swset_o = '0;
        if (wr_ok) begin
            unique case (idx)
                RIX_MASK:   r_d.mask  = wdata_i;
                RIX_SRCSEL: r_d.src   = wdata_i;
                RIX_POL:    r_d.pol   = wdata_i;
                RIX_SENSE:  r_d.sense = wdata_i;
                RIX_CLEAR:  clr_o     = wdata_i;
                RIX_SWREQ:  swset_o   = wdata_i;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.mask  <= '1;
            r_q.src   <= '0;
            r_q.pol   <= '1;
            r_q.sense <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (aligned) begin
            unique case (idx)
                RIX_MASK:   rdata_o = r_q.mask;
                RIX_SRCSEL: rdata_o = r_q.src;
                RIX_MSTAT:  rdata_o = masked_i;
                RIX_RSTAT:  rdata_o = raw_i;
                RIX_POL:    rdata_o = r_q.pol;
                RIX_SENSE:  rdata_o = r_q.sense;
                default:    rdata_o = '0;
            endcase
        end
    end

    assign mask_o  = r_q.mask;
    assign pol_o   = r_q.pol;
    assign sense_o = r_q.sense;

endmodule

// File: rtl/extirq_norm.sv
module extirq_norm #(
    parameter int unsigned NLINES      = 32,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NLINES-1:0] irq_line_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [NLINES-1:0] bus_wdata_i,
    output logic [NLINES-1:0] bus_rdata_o,
    output logic [NLINES-1:0] irq_o
);

    logic [NLINES-1:0] sync_w;
    logic [NLINES-1:0] mask_w;
    logic [NLINES-1:0] pol_w;
    logic [NLINES-1:0] sense_w;
    logic [NLINES-1:0] clr_w;
    logic [NLINES-1:0] swset_w;
    logic [NLINES-1:0] lvl_act_w;
    logic [NLINES-1:0] sticky_w;
    logic [NLINES-1:0] raw_w;
    logic [NLINES-1:0] masked_w;

    extirq_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_i),
        .rst_n (rst_ni),
        .din   (irq_line_i),
        .dout  (sync_w)
    );

    extirq_detect #(.W(NLINES)) u_detect (
        .clk       (clk_i),
        .rst_n     (rst_ni),
        .sync_i    (sync_w),
        .pol_i     (pol_w),
        .sense_i   (sense_w),
        .clr_i     (clr_w),
        .swset_i   (swset_w),
        .lvl_act_o (lvl_act_w),
        .sticky_o  (sticky_w),
        .raw_o     (raw_w)
    );

    extirq_regs #(.W(NLINES), .AW(ADDR_W)) u_regs (
        .clk      (clk_i),
        .rst_n    (rst_ni),
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .raw_i    (raw_w),
        .masked_i (masked_w),
        .rdata_o  (bus_rdata_o),
        .mask_o   (mask_w),
        .pol_o    (pol_w),
        .sense_o  (sense_w),
        .clr_o    (clr_w),
        .swset_o  (swset_w)
    );

    assign masked_w = raw_w & ~mask_w;
    assign irq_o    = masked_w;

endmodule

// File: rtl/extirq_norm_chk.sv
module extirq_norm_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] irq,
    input logic [W-1:0] mask,
    input logic [W-1:0] sense,
    input logic [W-1:0] lvl_act,
    input logic [W-1:0] sticky,
    input logic [W-1:0] clr,
    input logic [W-1:0] swset
);

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & mask) == '0)); // R3

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((($past(sticky) & ~$past(clr)) & ~sticky)) == '0)); // R7

    AST_SWREQ_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (swset != '0) |=> (($past(swset) & ~sticky) == '0)); // R8

    AST_LEVEL_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ((~sense & lvl_act & ~mask & ~irq) == '0)); // R4

endmodule

bind extirq_norm extirq_norm_chk #(.W(NLINES)) u_chk (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .irq     (irq_o),
    .mask    (mask_w),
    .sense   (sense_w),
    .lvl_act (lvl_act_w),
    .sticky  (sticky_w),
    .clr     (clr_w),
    .swset   (swset_w)
);

// File: tb/extirq_norm_test.sv
module extirq_norm_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lines = '0;
    logic        wr = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit started = 1'b0;

    // reference model state
    logic [31:0] m_mask = '1, m_src = '0, m_pol = '1, m_sense = '0, m_sticky = '0;
    logic [31:0] s1 = '0, s2 = '0, s3 = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    extirq_norm uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .irq_line_i  (lines),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    function automatic logic [31:0] m_raw();
        return m_sticky | (~m_sense & ~(s2 ^ m_pol));
    endfunction

    function automatic logic [31:0] exp_read(input int idx);
        case (idx)
            0: return m_mask;
            1: return m_src;
            2: return m_raw() & ~m_mask;
            3: return m_raw();
            5: return m_pol;
            6: return m_sense;
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [31:0] trig, clr, sw;
        if (!rst_n) begin
            m_mask = '1; m_src = '0; m_pol = '1; m_sense = '0; m_sticky = '0;
            s1 = '0; s2 = '0; s3 = '0;
        end else begin
            trig = (m_pol & s2 & ~s3) | (~m_pol & ~s2 & s3);
            clr  = (wr && addr == 5'h10) ? wdata : '0;
            sw   = (wr && addr == 5'h1C) ? wdata : '0;
            m_sticky = (m_sticky & ~clr) | (m_sense & trig) | sw;
            s3 = s2; s2 = s1; s1 = lines;
            if (wr && addr == 5'h00) m_mask  = wdata;
            if (wr && addr == 5'h04) m_src   = wdata;
            if (wr && addr == 5'h14) m_pol   = wdata;
            if (wr && addr == 5'h18) m_sense = wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // R9: outputs against the model on every cycle
    always @(negedge clk) begin
        if (rst_n && started) chk("R9", irq, m_raw() & ~m_mask);
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); #1;
        wr = 1'b0; wdata = '0;
    endtask

    task automatic read_chk(input string tag, input int idx);
        @(negedge clk); #1;
        addr = 5'(idx * 4);
        #2;
        chk(tag, rdata, exp_read(idx));
    endtask

    task automatic set_lines(input logic [31:0] v);
        @(negedge clk); #1;
        lines = v;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        started = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 out", irq, 32'h0);
        for (int i = 0; i < 8; i++) read_chk("R1", i);
        @(negedge clk); #1; addr = 5'h00; #2; chk("R1 mask", rdata, 32'hFFFF_FFFF);
        @(negedge clk); #1; addr = 5'h14; #2; chk("R1 pol", rdata, 32'hFFFF_FFFF);

        // R2: storage, read-only status, misaligned write
        bus_write(5'h04, 32'hA5A5_0F0F);
        read_chk("R2 src", 1);
        bus_write(5'h0C, 32'hFFFF_FFFF);
        bus_write(5'h08, 32'hFFFF_FFFF);
        read_chk("R2 rstat", 3);
        bus_write(5'h01, 32'h0);
        read_chk("R2 misaligned", 0);
        bus_write(5'h1C, 32'h0);
        read_chk("R2 swreq reads 0", 7);
        read_chk("R2 clear reads 0", 4);

        // R3: unmask low byte
        bus_write(5'h00, 32'hFFFF_FF00);
        read_chk("R3", 0);

        // R4: level, active high, two-clock latency
        set_lines(32'h0000_0001);
        @(negedge clk); chk("R4 lat1", irq & 32'h1, 32'h0);
        @(negedge clk); chk("R4 lat2", irq & 32'h1, 32'h1);
        // R4: active low on line 1 (input is 0)
        bus_write(5'h14, 32'hFFFF_FFFD);
        idle(1);
        chk("R4 low", irq & 32'h2, 32'h2);
        set_lines(32'h0000_0003);
        idle(3);
        chk("R4 low idle", irq & 32'h2, 32'h0);

        // R5: edge mode on lines 2 (rising) and 3 (falling)
        bus_write(5'h14, 32'hFFFF_FFF5);
        bus_write(5'h18, 32'h0000_040C);
        set_lines(32'h0000_0007);
        @(negedge clk); @(negedge clk);
        chk("R5 lat2", irq & 32'h4, 32'h0);
        @(negedge clk); chk("R5 lat3", irq & 32'h4, 32'h4);
        set_lines(32'h0000_0003);
        idle(4);
        chk("R5 hold", irq & 32'h4, 32'h4);
        chk("R5 no fall on rising line", irq & 32'h8, 32'h0);
        set_lines(32'h0000_000B);
        idle(4);
        chk("R5 rise on falling line", irq & 32'h8, 32'h0);
        set_lines(32'h0000_0003);
        idle(4);
        chk("R5 fall", irq & 32'h8, 32'h8);

        // R7: clear with zero, then with one
        bus_write(5'h10, 32'h0);
        read_chk("R7 zero", 3);
        chk("R7 zero kept", irq & 32'hC, 32'hC);
        bus_write(5'h10, 32'h0000_000C);
        read_chk("R7 cleared", 3);
        chk("R7 cleared out", irq & 32'hC, 32'h0);
        bus_write(5'h10, 32'h0000_0001);
        idle(1);
        chk("R7 level persists", irq & 32'h1, 32'h1);

        // R6: edge on masked line 10
        set_lines(32'h0000_0403);
        idle(4);
        read_chk("R6 raw", 3);
        chk("R6 raw bit", rdata & 32'h400, 32'h400);
        read_chk("R6 mstat", 2);
        chk("R6 out", irq & 32'h400, 32'h0);
        bus_write(5'h10, 32'h0000_0400);
        bus_write(5'h00, 32'hFFFF_FB00);
        idle(1);
        chk("R6 clean unmask", irq & 32'h400, 32'h0);

        // R8: software request on level line 5 and edge line 2
        bus_write(5'h1C, 32'h0000_0024);
        idle(1);
        chk("R8", irq & 32'h24, 32'h24);
        bus_write(5'h10, 32'h0000_0024);
        idle(1);
        chk("R8 cleared", irq & 32'h24, 32'h0);

        // R10: clear and rising edge on line 2 take effect together
        set_lines(32'h0000_0407);
        @(negedge clk);
        bus_write(5'h10, 32'h0000_0004);
        idle(1);
        chk("R10", irq & 32'h4, 32'h4);

        // R9: masked status read against mask change
        bus_write(5'h00, 32'hFFFF_FFFB);
        read_chk("R9 mstat", 2);
        read_chk("R9 rstat", 3);

        idle(3);
        started = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule